// File: doc/BRIEF.md
# SPI Host Transfer Scheduler

This block is the host-side controller for a full-duplex SPI link to a peripheral that signals when it is ready. It pulses the peripheral's reset line at start-up, then ignores the handshake line for a short guard time. After that it watches the handshake and data-ready lines and runs a fixed-length transfer of `FRAME_BYTES` bytes as the SPI controller. A transfer starts only while the handshake line is high, and only when the peripheral has data or the host has a frame waiting. If neither holds when the handshake line rises, the scheduler waits. It starts the transfer later if one of the two becomes true while the handshake line is still high.

Every frame in either direction begins with a three-byte header: the payload length, low byte first, and then a kind byte. The upper layers stay cut off until a frame of the init kind arrives. The host frame to send is announced by a request level and a length, and its payload bytes are pulled over a valid/ready stream while the transfer runs. Received payload bytes leave on a valid/ready stream with a last flag. Back-pressure on either stream pauses SCLK between bytes. SCLK never stops inside a byte.

Top module: `shx_host_sched`

## Requirements
- R1: After `rst_n` is released, `per_rst_n` stays low for exactly `RST_CYCLES` clock edges and then stays high. `cs_n` stays high while `per_rst_n` is low.
- R2: A rising edge of `hs_in` that occurs during the `GUARD_CYCLES` cycles after `per_rst_n` rises never starts a transfer.
- R3: `cs_n` falls only while the synchronized handshake is high. A handshake rise starts a transfer only if data-ready is high or a host frame is pending. A frame is pending when `tx_req` is high, `tx_len` is non-zero and `link_open` is high.
- R4: A deferred start happens without a new handshake edge. Once the handshake has risen and stays high, the transfer starts as soon as data-ready goes high or a host frame becomes pending.
- R5: Every transfer holds `cs_n` low for exactly `FRAME_BYTES*8` SCLK rising edges. It uses SPI mode 0, MSB first. Each SCLK high phase lasts `CLK_DIV/2` clock cycles, and SCLK is low whenever `cs_n` is high.
- R6: The transmitted frame has byte 0 = length[7:0], byte 1 = length[15:8] and byte 2 = kind 0x01, followed by the payload and then zero bytes. The length is `tx_len` clipped to `FRAME_BYTES-3`. With no pending frame, every transmitted byte is 0x00.
- R7: `link_open` is low after reset and rises after a received frame whose kind byte (byte 2) is 0x02. Once high it stays high. Init frames are never delivered, and no frame received before `link_open` rises is delivered.
- R8: A received frame of kind 0x01 with non-zero length is delivered on `rx_*`. Its length is read from bytes 0–1, little-endian, and clipped to `FRAME_BYTES-3`. Exactly that many bytes are delivered, starting at byte 3, and `rx_last` is set only on the final one. Frames of length 0 and padding bytes are never presented.
- R9: While `rx_valid` is high and `rx_ready` is low, `rx_valid`, `rx_data` and `rx_last` hold. The transfer pauses without losing bytes.
- R10: `tx_taken` pulses for one cycle when a pending frame is latched into a transfer. Payload bytes are accepted only on `tx_valid && tx_ready` cycles, and `tx_ready` is high only while `cs_n` is low.
- R11: One handshake rise allows at most one transfer. For another transfer, the handshake must fall and rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| per_rst_n | output | 1 | Active-low reset to the peripheral |
| hs_in | input | 1 | Peripheral handshake (ready for transfer), asynchronous |
| drdy_in | input | 1 | Peripheral has data to send, asynchronous |
| sclk | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | Controller data out |
| miso | input | 1 | Controller data in |
| cs_n | output | 1 | Active-low chip select |
| link_open | output | 1 | Upper-layer data path open |
| tx_req | input | 1 | Host frame pending (level) |
| tx_len | input | 16 | Payload length of pending frame |
| tx_taken | output | 1 | One-cycle pulse: pending frame latched |
| tx_data | input | 8 | Host payload byte |
| tx_valid | input | 1 | `tx_data` valid |
| tx_ready | output | 1 | Scheduler takes `tx_data` this cycle |
| rx_data | output | 8 | Delivered payload byte |
| rx_valid | output | 1 | `rx_data` valid |
| rx_last | output | 1 | Final byte of the delivered payload |
| rx_ready | input | 1 | Sink accepts `rx_data` |

## Verification
The bench builds the block with `FRAME_BYTES=8`, `CLK_DIV=4`, `RST_CYCLES=6` and `GUARD_CYCLES=12`. An 8-byte frame leaves five payload bytes. So every receive and transmit length from 0 to 5 can be swept, along with a length above 5 that must be clipped. The short reset and guard times let the bench measure both exactly, and each transfer finishes in a few hundred cycles. The bench also drives the rx sink with a periodic `rx_ready` pattern so that SCLK pauses between bytes.

// File: rtl/shx_pkg.sv
package shx_pkg;
  localparam int HDR_BYTES = 3;
  localparam logic [7:0] KIND_DATA = 8'h01;
  localparam logic [7:0] KIND_INIT = 8'h02;

  typedef enum logic [2:0] {
    S_RST, S_GUARD, S_IDLE, S_PREP, S_SHIFT, S_END
  } sched_st_e;

  function automatic logic [15:0] clip_len(input logic [15:0] len, input logic [15:0] lim);
    return (len > lim) ? lim : len;
  endfunction
endpackage

// File: rtl/shx_byte_shifter.sv
// One SPI mode-0 byte, MSB first: MOSI is set while SCLK is low, MISO is
// captured on the rising edge.
module shx_byte_shifter #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi
);
  localparam int HALF = CLK_DIV / 2;
  localparam int HW   = $clog2(HALF + 1);

  logic          busy_q, phase_hi, sclk_q, done_q;
  logic [HW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh_tx, sh_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; phase_hi <= 1'b0; sclk_q <= 1'b0; done_q <= 1'b0;
      cnt <= '0; bitn <= '0; sh_tx <= '0; sh_rx <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1; sh_tx <= tx_byte; cnt <= '0;
          bitn <= '0; phase_hi <= 1'b0; sclk_q <= 1'b0;
        end
      end else if (cnt != HW'(HALF - 1)) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (!phase_hi) begin
          sclk_q   <= 1'b1;
          phase_hi <= 1'b1;
          sh_rx    <= {sh_rx[6:0], miso};
        end else begin
          sclk_q   <= 1'b0;
          phase_hi <= 1'b0;
          if (bitn == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bitn  <= bitn + 1'b1;
            sh_tx <= {sh_tx[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign done    = done_q;
  assign rx_byte = sh_rx;
  assign sclk    = sclk_q;
  assign mosi    = sh_tx[7];

  assert_sclk_low_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> (!sclk_q || busy_q));
endmodule

// File: rtl/shx_tx_framer.sv
// Chooses the byte to shift out at each frame position.
module shx_tx_framer import shx_pkg::*; #(
  parameter int FRAME_BYTES = 1600,
  localparam int IW = $clog2(FRAME_BYTES + 1)
) (
  input  logic [IW-1:0] idx,
  input  logic          frame_ok,
  input  logic [15:0]   flen,
  input  logic [7:0]    tx_data,
  output logic [7:0]    byte_out,
  output logic          need_stream
);
  logic [IW-1:0] pay_off;
  logic          in_pay;

  assign pay_off     = idx - IW'(HDR_BYTES);
  assign in_pay      = frame_ok && (idx >= IW'(HDR_BYTES)) && (pay_off < flen[IW-1:0]);
  assign need_stream = in_pay;

  always_comb begin
    byte_out = 8'h00;
    if (frame_ok) begin
      if (idx == IW'(0))                  byte_out = flen[7:0];
      else if (idx == IW'(1))             byte_out = flen[15:8];
      else if (idx == IW'(HDR_BYTES - 1)) byte_out = KIND_DATA;
      else if (in_pay)                    byte_out = tx_data;
    end
  end
endmodule

// File: rtl/shx_rx_sink.sv
// Parses the received header and presents the payload bytes on a valid/ready stream.
module shx_rx_sink import shx_pkg::*; #(
  parameter int FRAME_BYTES = 1600,
  localparam int IW = $clog2(FRAME_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [IW-1:0] in_idx,
  input  logic [7:0]    in_byte,
  output logic          room,
  output logic          link_open,
  output logic [7:0]    out_data,
  output logic          out_valid,
  output logic          out_last,
  input  logic          out_ready
);
  localparam logic [15:0] MAXP = 16'(FRAME_BYTES - HDR_BYTES);

  logic [15:0]   len_q, eff_len;
  logic [IW-1:0] eff_q, pay_off;
  logic          deliver_q, open_q, ov_q, last_q;
  logic [7:0]    data_q;

  assign eff_len = clip_len(len_q, MAXP);
  assign pay_off = in_idx - IW'(HDR_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0; eff_q <= '0; deliver_q <= 1'b0; open_q <= 1'b0;
      ov_q <= 1'b0; last_q <= 1'b0; data_q <= '0;
    end else begin
      if (ov_q && out_ready) ov_q <= 1'b0;
      if (in_valid) begin
        if (in_idx == IW'(0)) begin
          len_q[7:0] <= in_byte;
          deliver_q  <= 1'b0;
        end else if (in_idx == IW'(1)) begin
          len_q[15:8] <= in_byte;
        end else if (in_idx == IW'(HDR_BYTES - 1)) begin
          if (in_byte == KIND_INIT) open_q <= 1'b1;
          deliver_q <= open_q && (in_byte == KIND_DATA) && (len_q != 16'd0);
          eff_q     <= eff_len[IW-1:0];
        end else if (deliver_q && pay_off < eff_q) begin
          ov_q   <= 1'b1;
          data_q <= in_byte;
          last_q <= (pay_off == eff_q - 1'b1);
        end
      end
    end
  end

  assign room      = !ov_q;
  assign link_open = open_q;
  assign out_data  = data_q;
  assign out_valid = ov_q;
  assign out_last  = last_q;

  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !out_ready) |=> (ov_q && $stable(data_q) && $stable(last_q)));
  assert_open_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |=> open_q);
endmodule

// File: rtl/shx_host_sched.sv
module shx_host_sched import shx_pkg::*; #(
  parameter int FRAME_BYTES  = 1600,
  parameter int CLK_DIV      = 4,
  parameter int RST_CYCLES   = 1000,
  parameter int GUARD_CYCLES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        per_rst_n,
  input  logic        hs_in,
  input  logic        drdy_in,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n,
  output logic        link_open,
  input  logic        tx_req,
  input  logic [15:0] tx_len,
  output logic        tx_taken,
  input  logic [7:0]  tx_data,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic [7:0]  rx_data,
  output logic        rx_valid,
  output logic        rx_last,
  input  logic        rx_ready
);
  localparam int IW      = $clog2(FRAME_BYTES + 1);
  localparam int CNT_MAX = (RST_CYCLES > GUARD_CYCLES) ? RST_CYCLES : GUARD_CYCLES;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [15:0] MAXP = 16'(FRAME_BYTES - HDR_BYTES);

  sched_st_e     st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          per_rst_q, cs_q, frame_ok, tx_taken_q, armed;
  logic [15:0]   flen;
  logic          hs_m, hs_s, hs_d, dr_m, dr_s;
  logic          pend, go, launch, need_stream, room, sh_done;
  logic [7:0]    tx_byte, rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_m <= 1'b0; hs_s <= 1'b0; hs_d <= 1'b0; dr_m <= 1'b0; dr_s <= 1'b0;
    end else begin
      hs_m <= hs_in; hs_s <= hs_m; hs_d <= hs_s;
      dr_m <= drdy_in; dr_s <= dr_m;
    end
  end

  assign pend     = link_open && tx_req && (tx_len != 16'd0);
  assign go       = (st == S_IDLE) && armed && hs_s && (dr_s || pend);
  assign launch   = (st == S_PREP) && room && (!need_stream || tx_valid);
  assign tx_ready = (st == S_PREP) && room && need_stream;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RST; cnt <= '0; idx <= '0; per_rst_q <= 1'b0; cs_q <= 1'b1;
      frame_ok <= 1'b0; flen <= '0; tx_taken_q <= 1'b0; armed <= 1'b0;
    end else begin
      tx_taken_q <= 1'b0;
      if (!hs_s) armed <= 1'b0;
      else if (!hs_d && st != S_RST && st != S_GUARD) armed <= 1'b1;
      case (st)
        S_RST: begin
          if (cnt == CW'(RST_CYCLES - 1)) begin
            cnt <= '0; per_rst_q <= 1'b1; st <= S_GUARD;
          end else cnt <= cnt + 1'b1;
        end
        S_GUARD: begin
          if (cnt == CW'(GUARD_CYCLES - 1)) begin
            cnt <= '0; st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_IDLE: begin
          if (go) begin
            armed      <= 1'b0;
            cs_q       <= 1'b0;
            idx        <= '0;
            frame_ok   <= pend;
            flen       <= clip_len(tx_len, MAXP);
            tx_taken_q <= pend;
            st         <= S_PREP;
          end
        end
        S_PREP:  if (launch) st <= S_SHIFT;
        S_SHIFT: begin
          if (sh_done) begin
            if (idx == IW'(FRAME_BYTES - 1)) st <= S_END;
            else begin
              idx <= idx + 1'b1;
              st  <= S_PREP;
            end
          end
        end
        S_END: begin
          cs_q <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  shx_tx_framer #(.FRAME_BYTES(FRAME_BYTES)) u_framer (
    .idx(idx), .frame_ok(frame_ok), .flen(flen), .tx_data(tx_data),
    .byte_out(tx_byte), .need_stream(need_stream)
  );

  shx_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(launch), .tx_byte(tx_byte), .miso(miso),
    .done(sh_done), .rx_byte(rx_byte), .sclk(sclk), .mosi(mosi)
  );

  shx_rx_sink #(.FRAME_BYTES(FRAME_BYTES)) u_sink (
    .clk(clk), .rst_n(rst_n), .in_valid((st == S_SHIFT) && sh_done), .in_idx(idx),
    .in_byte(rx_byte), .room(room), .link_open(link_open), .out_data(rx_data),
    .out_valid(rx_valid), .out_last(rx_last), .out_ready(rx_ready)
  );

  assign per_rst_n = per_rst_q;
  assign cs_n      = cs_q;
  assign tx_taken  = tx_taken_q;

  assert_cs_needs_hs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> $past(hs_s));
  assert_no_xfer_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !per_rst_q |-> cs_q);
  assert_tx_ready_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !cs_q);
  assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !sclk);
endmodule

// File: tb/tb_shx_host_sched.sv
module tb_shx_host_sched;
  localparam int FB = 8, CD = 4, RC = 6, GC = 12;
  localparam int NB = FB * 8, MAXP = FB - 3, HALF = CD / 2;

  logic clk = 0, rst_n = 0;
  logic per_rst_n, hs_in = 0, drdy_in = 0, sclk, mosi, miso = 0, cs_n, link_open;
  logic tx_req = 0, tx_taken, tx_ready, tx_valid = 1, rx_valid, rx_last, rx_ready = 1;
  logic [15:0] tx_len = 0;
  logic [7:0] tx_data, rx_data;

  int checks = 0, fails = 0, bi = 0, tidx = 0, rcnt = 0, hi_cnt = 0, cyc = 0;
  bit bp_mode = 0;
  logic [7:0] pb [FB];
  logic [7:0] mb [FB];
  logic [7:0] tpay [8];
  logic [7:0] rbuf [128];
  logic       rlast [128];

  always #2 clk = ~clk;

  shx_host_sched #(.FRAME_BYTES(FB), .CLK_DIV(CD), .RST_CYCLES(RC), .GUARD_CYCLES(GC)) dut (
    .clk(clk), .rst_n(rst_n), .per_rst_n(per_rst_n), .hs_in(hs_in), .drdy_in(drdy_in),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .link_open(link_open),
    .tx_req(tx_req), .tx_len(tx_len), .tx_taken(tx_taken), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_last(rx_last), .rx_ready(rx_ready)
  );

  // Peripheral SPI model, mode 0
  always @(negedge cs_n) begin bi = 0; miso = pb[0][7]; end
  always @(posedge sclk) begin
    if (bi < NB) mb[bi / 8][7 - (bi % 8)] = mosi;
    bi = bi + 1;
  end
  always @(negedge sclk) if (bi < NB) miso = pb[bi / 8][7 - (bi % 8)];

  assign tx_data = tpay[tidx % 8];
  always @(posedge clk) begin
    if (tx_taken) begin tidx <= 0; tx_req <= 0; end
    else if (tx_valid && tx_ready) tidx <= tidx + 1;
    if (rx_valid && rx_ready) begin
      rbuf[rcnt % 128] <= rx_data; rlast[rcnt % 128] <= rx_last; rcnt <= rcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // SCLK high-phase width monitor (R5), plus back-pressure pattern (R9)
  always @(negedge clk) begin
    cyc++;
    rx_ready = bp_mode ? (cyc % 3 == 0) : 1'b1;
    if (sclk) hi_cnt++;
    else if (hi_cnt != 0) begin
      chk(hi_cnt == HALF, "R5 sclk high width", hi_cnt, HALF);
      hi_cnt = 0;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  task automatic ticks(input int n); repeat (n) @(negedge clk); endtask

  // Wait for a transfer; expect tells whether one must occur. Drops hs/drdy after it if drop.
  task automatic xfer(input bit expect_go, input bit drop, input string req);
    bit seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!cs_n) begin seen = 1; break; end
    end
    chk(seen == expect_go, req, seen, expect_go);
    if (seen) begin
      for (int i = 0; i < 4000 && !cs_n; i++) @(negedge clk);
      chk(bi == NB, "R5 sclk edges per frame", bi, NB);
      if (drop) begin hs_in = 0; drdy_in = 0; end
      ticks(8);
    end
  endtask

  task automatic set_rx(input int len, input logic [7:0] kind);
    foreach (pb[i]) pb[i] = 8'h00;
    pb[0] = len[7:0]; pb[1] = len[15:8]; pb[2] = kind;
    for (int i = 3; i < FB; i++) pb[i] = 8'h50 + 8'(i);
  endtask

  task automatic chk_rx(input int base, input int n, input string req);
    chk(rcnt - base == n, req, rcnt - base, n);
    for (int k = 0; k < n && k < rcnt - base; k++) begin
      chk(rbuf[(base + k) % 128] == 8'h50 + 8'(k + 3), req, rbuf[(base + k) % 128], 8'h50 + k + 3);
      chk(rlast[(base + k) % 128] == (k == n - 1), {req, " last"}, rlast[(base + k) % 128], k == n - 1);
    end
  endtask

  initial begin
    int base, lowc, e;
    foreach (pb[i]) pb[i] = 0;
    foreach (tpay[i]) tpay[i] = 8'h30 + 8'(i);
    ticks(3);
    chk(per_rst_n == 0 && cs_n == 1 && sclk == 0 && link_open == 0 && rx_valid == 0,
        "R1 reset state", {per_rst_n, cs_n, sclk, link_open}, 4'b0100);
    rst_n = 1;
    lowc = 0;
    while (per_rst_n == 0 && lowc < 100) begin lowc++; @(negedge clk); end
    chk(lowc == RC, "R1 reset pulse length", lowc, RC);

    // R2: handshake rise inside guard interval is ignored
    ticks(1); hs_in = 1; drdy_in = 1;
    xfer(0, 1, "R2 guard ignores handshake");
    hs_in = 0; drdy_in = 0; ticks(4);

    // R3: host frame pending before link open does not start a transfer
    tx_req = 1; tx_len = 2; set_rx(2, 8'h01);
    hs_in = 1;
    xfer(0, 0, "R3 frame ignored before open");
    // R4: deferred start when data-ready rises; R6 idle header; R7 not delivered
    base = rcnt; drdy_in = 1;
    xfer(1, 1, "R4 deferred start on data-ready");
    for (int i = 0; i < FB; i++) chk(mb[i] == 0, "R6 idle frame all zero", mb[i], 0);
    chk(rcnt == base, "R7 frame before open dropped", rcnt - base, 0);
    chk(link_open == 0, "R7 still closed", link_open, 0);
    tx_req = 0;

    // R7: INIT opens path, not delivered
    set_rx(3, 8'h02); base = rcnt;
    hs_in = 1; drdy_in = 1;
    xfer(1, 1, "R7 init transfer");
    chk(link_open == 1, "R7 link opened", link_open, 1);
    chk(rcnt == base, "R7 init not delivered", rcnt - base, 0);

    // R3: handshake rise with nothing to do
    hs_in = 1;
    xfer(0, 0, "R3 no data no frame");
    hs_in = 0; ticks(4);

    // R8: receive length sweep including clip
    for (int L = 0; L <= MAXP + 1; L++) begin
      set_rx(L, 8'h01); base = rcnt;
      hs_in = 1; drdy_in = 1;
      xfer(1, 1, "R8 rx transfer");
      e = (L > MAXP) ? MAXP : L;
      chk_rx(base, e, "R8 rx payload");
    end
    // R8: unknown kind dropped
    set_rx(3, 8'h07); base = rcnt; hs_in = 1; drdy_in = 1;
    xfer(1, 1, "R8 other kind transfer");
    chk(rcnt == base, "R8 other kind dropped", rcnt - base, 0);

    // R6/R10/R4: transmit length sweep
    set_rx(0, 8'h00);
    for (int L = 1; L <= MAXP + 2; L++) begin
      e = (L > MAXP) ? MAXP : L;
      tx_len = 16'(L);
      if (L % 2 == 1) begin
        tx_req = 1; ticks(1); hs_in = 1;
        xfer(1, 1, "R10 tx immediate start");
      end else begin
        hs_in = 1;
        xfer(0, 0, "R3 armed but idle");
        tx_req = 1;
        xfer(1, 1, "R4 deferred start on frame");
      end
      chk(tx_req == 0, "R10 tx_taken seen", tx_req, 0);
      chk(mb[0] == 8'(e) && mb[1] == 0 && mb[2] == 8'h01, "R6 header", {mb[0], mb[1], mb[2]}, {8'(e), 8'h00, 8'h01});
      for (int k = 3; k < FB; k++)
        chk(mb[k] == ((k - 3 < e) ? 8'h30 + 8'(k - 3) : 8'h00), "R6 payload and padding", mb[k],
            (k - 3 < e) ? 8'h30 + k - 3 : 0);
    end

    // R9: rx back-pressure
    bp_mode = 1; set_rx(MAXP, 8'h01); base = rcnt;
    hs_in = 1; drdy_in = 1;
    xfer(1, 1, "R9 transfer under back-pressure");
    ticks(10);
    chk_rx(base, MAXP, "R9 payload under back-pressure");
    bp_mode = 0;

    // R11: handshake held high allows only one transfer
    set_rx(0, 8'h00); hs_in = 1; drdy_in = 1;
    xfer(1, 0, "R11 first transfer");
    xfer(0, 0, "R11 no second transfer without new edge");
    hs_in = 0; drdy_in = 0; ticks(4);
    chk(link_open == 1, "R7 stays open", link_open, 1);

    summary();
  end
endmodule